// File: doc/BRIEF.md
# Multi-Sector Erase Gathering Window

This block collects the sectors of a multi-sector erase before the erase begins. The first decoded sector-erase write opens an acceptance window of a fixed number of clock cycles and selects its sector in a bitmap. Every further sector-erase write made while the window is open adds its sector to the bitmap and starts the window over. When the window runs out, the block emits a one-clock start pulse that carries the final bitmap.

While the window is open, an erase-suspend write closes it at once and starts the erase with a suspended flag raised. Any other command aborts the gathered erase and clears the bitmap. A status output is low only while sectors can still be added. The erase algorithm that consumes the start pulse lies outside this block.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `sel_map` is all zeros, `erase_go` and `erase_abort` are low, and `win_closed` is high.
- R2: A `se_wr` strobe while the window is closed opens the window. From the next cycle `win_closed` is low and `sel_map` holds only bit `se_sect`, where bit i stands for sector i. Any earlier selection is dropped.
- R3: If no strobe arrives while the window is open, `erase_go` rises exactly `WIN_CYC` clocks after the edge that took the last sector-erase write. In that same cycle `win_closed` goes high and `start_susp` is 0.
- R4: A `se_wr` while the window is open sets bit `se_sect` in `sel_map` and keeps every bit already set. Writing a sector that is already selected leaves the map unchanged.
- R5: A `se_wr` while the window is open restarts the window, so the `WIN_CYC` count starts again from that write.
- R6: An `oth_wr` while the window is open raises `erase_abort` for one clock in the next cycle. In that cycle `sel_map` is zero and `win_closed` is high. No `erase_go` follows.
- R7: A `susp_wr` while the window is open, with no `oth_wr`, raises `erase_go` in the next cycle with `start_susp` at 1 and `win_closed` high.
- R8: `erase_go` lasts exactly one clock. `sel_map` stays at the started selection until the next R2 opening.
- R9: When strobes coincide while the window is open, `oth_wr` wins over `susp_wr`, and `susp_wr` wins over `se_wr`. A sector written together with a suspend is not added to the map.
- R10: While the window is closed, `susp_wr` and `oth_wr` have no effect: no pulse is produced and `sel_map` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| se_wr | input | 1 | Decoded sector-erase write strobe, one per write |
| se_sect | input | SW | Sector index that comes with `se_wr` |
| susp_wr | input | 1 | Decoded erase-suspend write strobe |
| oth_wr | input | 1 | Strobe for any other command write |
| sel_map | output | NSECT | Bitmap of the selected sectors |
| erase_go | output | 1 | One-clock pulse that starts the erase |
| start_susp | output | 1 | Set with `erase_go` when the erase starts suspended |
| erase_abort | output | 1 | One-clock pulse when a gathered erase is abandoned |
| win_closed | output | 1 | Low while more sectors can be added |

## Verification
The assertions assume that the command decoder upstream gives each write exactly one clock of strobe. They also assume that `se_sect` is valid in any cycle where `se_wr` is high. The stimulus keeps to this by raising each strobe on a falling edge and dropping it on the next falling edge. Coinciding strobes are driven only in the cases that test priority on purpose.

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
  parameter int NSECT   = 16,
  parameter int WIN_CYC = 20000,
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1,
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se_wr,
  input  logic [SW-1:0]    se_sect,
  input  logic             susp_wr,
  input  logic             oth_wr,
  output logic [NSECT-1:0] sel_map,
  output logic             erase_go,
  output logic             start_susp,
  output logic             erase_abort,
  output logic             win_closed
);

  logic          open_q;
  logic [CW-1:0] cnt;
  logic [NSECT-1:0] sect_bit;

  assign sect_bit   = {{(NSECT-1){1'b0}}, 1'b1} << se_sect;
  assign win_closed = ~open_q;

  wire expire = (cnt == CW'(WIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q      <= 1'b0;
      cnt         <= '0;
      sel_map     <= '0;
      erase_go    <= 1'b0;
      start_susp  <= 1'b0;
      erase_abort <= 1'b0;
    end else begin
      erase_go    <= 1'b0;
      erase_abort <= 1'b0;
      if (!open_q) begin
        if (se_wr) begin
          open_q  <= 1'b1;
          cnt     <= '0;
          sel_map <= sect_bit;
        end
      end else if (oth_wr) begin
        open_q      <= 1'b0;
        sel_map     <= '0;
        erase_abort <= 1'b1;
      end else if (susp_wr) begin
        open_q     <= 1'b0;
        erase_go   <= 1'b1;
        start_susp <= 1'b1;
      end else if (se_wr) begin
        cnt     <= '0;
        sel_map <= sel_map | sect_bit;
      end else if (expire) begin
        open_q     <= 1'b0;
        erase_go   <= 1'b1;
        start_susp <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_GO_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> !erase_go); // R8
  AST_GO_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> win_closed); // R3
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    erase_abort |-> (sel_map == '0) && win_closed && !erase_go); // R6
  AST_SUSP_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_closed && susp_wr && !oth_wr) |=> erase_go && start_susp); // R7
  AST_OTHER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_closed && oth_wr) |=> erase_abort && !erase_go); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_closed && !se_wr) |=> $stable(sel_map) && !erase_abort); // R10
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WIN_CYC)); // R5

endmodule

// File: tb/sim_sector_erase_window.sv
module sim_sector_erase_window;
  localparam int NSECT = 8;
  localparam int WIN   = 12;
  localparam int SW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic se_wr = 1'b0, susp_wr = 1'b0, oth_wr = 1'b0;
  logic [SW-1:0] se_sect = '0;
  logic [NSECT-1:0] sel_map;
  logic erase_go, start_susp, erase_abort, win_closed;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  sector_erase_window #(.NSECT(NSECT), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .se_wr(se_wr), .se_sect(se_sect),
    .susp_wr(susp_wr), .oth_wr(oth_wr), .sel_map(sel_map),
    .erase_go(erase_go), .start_susp(start_susp),
    .erase_abort(erase_abort), .win_closed(win_closed));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic s, input logic p, input logic o, input int sect);
    @(negedge clk);
    se_wr = s; susp_wr = p; oth_wr = o; se_sect = SW'(sect);
    @(negedge clk);
    se_wr = 0; susp_wr = 0; oth_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (!erase_go && n < WIN + 5) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    chk("R1 map", int'(sel_map), 0);
    chk("R1 go", int'(erase_go), 0);
    chk("R1 abort", int'(erase_abort), 0);
    chk("R1 closed", int'(win_closed), 1);
  endtask

  task automatic t_single();
    int n;
    strobe(1, 0, 0, 3);
    chk("R2 open", int'(win_closed), 0);
    chk("R2 map", int'(sel_map), 8);
    wait_go(n);
    chk("R3 window length", n, WIN);
    chk("R3 closed", int'(win_closed), 1);
    chk("R3 not suspended", int'(start_susp), 0);
    chk("R8 map with go", int'(sel_map), 8);
    @(negedge clk);
    chk("R8 go one clock", int'(erase_go), 0);
    chk("R8 map held", int'(sel_map), 8);
  endtask

  task automatic t_multi();
    int n;
    strobe(1, 0, 0, 1);
    chk("R2 fresh map", int'(sel_map), 2);
    idle(5);
    strobe(1, 0, 0, 5);
    strobe(1, 0, 0, 5);
    chk("R4 map", int'(sel_map), 8'h22);
    wait_go(n);
    chk("R5 restart", n, WIN);
    chk("R4 final map", int'(sel_map), 8'h22);
  endtask

  task automatic t_abort();
    int gos = 0;
    strobe(1, 0, 0, 2);
    idle(3);
    strobe(0, 0, 1, 0);
    chk("R6 abort", int'(erase_abort), 1);
    chk("R6 map clear", int'(sel_map), 0);
    chk("R6 closed", int'(win_closed), 1);
    for (int i = 0; i < WIN + 3; i++) begin
      @(negedge clk);
      if (erase_go) gos++;
    end
    chk("R6 no go", gos, 0);
  endtask

  task automatic t_susp();
    strobe(1, 0, 0, 4);
    idle(2);
    strobe(0, 1, 0, 0);
    chk("R7 go", int'(erase_go), 1);
    chk("R7 suspended", int'(start_susp), 1);
    chk("R7 closed", int'(win_closed), 1);
    chk("R7 map", int'(sel_map), 8'h10);
  endtask

  task automatic t_idle();
    int ev = 0;
    strobe(0, 0, 1, 0);
    if (erase_go || erase_abort) ev++;
    strobe(0, 1, 0, 0);
    if (erase_go || erase_abort) ev++;
    idle(2);
    chk("R10 no pulse", ev, 0);
    chk("R10 map kept", int'(sel_map), 8'h10);
    chk("R10 closed", int'(win_closed), 1);
  endtask

  task automatic t_prio();
    strobe(1, 0, 0, 0);
    strobe(1, 1, 0, 6);
    chk("R9 suspend over sector go", int'(erase_go), 1);
    chk("R9 sector not added", int'(sel_map), 1);
    idle(2);
    strobe(1, 0, 0, 0);
    strobe(1, 1, 1, 6);
    chk("R9 other wins abort", int'(erase_abort), 1);
    chk("R9 other wins no go", int'(erase_go), 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_single();
    t_multi();
    t_abort();
    t_susp();
    t_idle();
    t_prio();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule